// File: doc/BRIEF.md
# Cascadable synchronous presettable binary counter

The block is a chain of identical up-counting stages. Each stage is `STAGE_W` bits wide (4 by default) and counts modulo 2^`STAGE_W`. The stages share one clock and together form a `STAGE_W*N_STAGES`-bit counter (8 bits by default).

Every change of the count happens on the rising clock edge. Four modes are selected in fixed priority order:

1. An active-low synchronous clear.
2. An active-low synchronous parallel load.
3. Count up, which needs both enables high.
4. Hold.

There are two enables. The parallel enable goes to every stage. The trickle enable enters the first stage. Each later stage takes its trickle enable from the terminal-count flag of the stage before it.

The terminal-count flag of a stage is a combinational decode: the stage is at its maximum and its trickle enable is high. The parallel enable plays no part in it. The flag of the last stage is the block's carry out, so a user can extend the count further in the same way. The carry out must never be used as a clock or as an asynchronous reset. A house-standard active-low asynchronous reset sets the count to zero.

Top module: `sync_chain_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0.
- R2: When `clr_ni` is low at a rising edge, `count_o` becomes 0 after that edge, whatever `load_ni`, `cnt_en_i`, `carry_en_i` and `data_i` are.
- R3: When `clr_ni` is high and `load_ni` is low at a rising edge, `count_o` becomes `data_i` after that edge. The enables are ignored.
- R4: When `clr_ni`, `load_ni`, `cnt_en_i` and `carry_en_i` are all high at a rising edge, `count_o` becomes (`count_o` + 1) mod 2^`CNT_W`. The count wraps from all ones to 0.
- R5: When `clr_ni` and `load_ni` are high and either `cnt_en_i` or `carry_en_i` is low at a rising edge, `count_o` keeps its value.
- R6: `tc_o` is 1 exactly when `count_o` is all ones and `carry_en_i` is 1. It follows `carry_en_i` in the same cycle, and `cnt_en_i` does not affect it.
- R7: While counting, the upper stage (`count_o[7:4]` by default) advances only on the edge where the lower stage (`count_o[3:0]`) wraps from 15 to 0. On every other counting edge it holds.
- R8: After a load of all ones, `tc_o` equals `carry_en_i` in the following cycle, even if `carry_en_i` was low during the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_ni | input | 1 | Active-low synchronous clear, highest priority |
| load_ni | input | 1 | Active-low synchronous parallel load |
| cnt_en_i | input | 1 | Parallel count enable, shared by all stages |
| carry_en_i | input | 1 | Trickle enable into the first stage |
| data_i | input | CNT_W | Parallel load value |
| count_o | output | CNT_W | Current count |
| tc_o | output | 1 | Terminal count of the last stage (carry out) |

## Verification
The count is a single register stage, so a clear, a load, an increment or a hold is due one edge after the inputs that select it. The bench changes its inputs on the falling edge and reads `count_o` 1 ns after the following rising edge. `tc_o` is combinational, so the bench reads it 1 ns after the inputs change and before the next rising edge. This confirms that it follows `carry_en_i` within the same cycle. The expected values come from an arithmetic model applied edge by edge, across:
- all 256 load values;
- a full count through the wrap;
- every combination of the control inputs under clear and under hold.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_INC  = 2'd1,
    MODE_LOAD = 2'd2,
    MODE_CLR  = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import sync_cnt_pkg::*;
(
  input  logic      clr_ni,
  input  logic      load_ni,
  input  logic      par_en_i,
  input  logic      trk_en_i,
  output cnt_mode_e mode_o
);
  // priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)                    mode_o = MODE_CLR;
    else if (!load_ni)              mode_o = MODE_LOAD;
    else if (par_en_i && trk_en_i)  mode_o = MODE_INC;
    else                            mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import sync_cnt_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         load_ni,
  input  logic         par_en_i,
  input  logic         trk_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o,
  output logic         tc_o
);
  cnt_mode_e mode;
  logic [W-1:0] q_q;

  cnt_mode_dec u_dec (
    .clr_ni  (clr_ni),
    .load_ni (load_ni),
    .par_en_i(par_en_i),
    .trk_en_i(trk_en_i),
    .mode_o  (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (mode)
        MODE_CLR:  q_q <= '0;
        MODE_LOAD: q_q <= data_i;
        MODE_INC:  q_q <= q_q + 1'b1;
        default:   q_q <= q_q;
      endcase
    end
  end

  assign q_o  = q_q;
  // carry decode: gated by trickle enable only
  assign tc_o = (&q_q) & trk_en_i;
endmodule

// File: rtl/sync_chain_counter.sv
module sync_chain_counter #(
  parameter int unsigned STAGE_W  = 4,
  parameter int unsigned N_STAGES = 2,
  localparam int unsigned CNT_W   = STAGE_W * N_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             cnt_en_i,
  input  logic             carry_en_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  logic [N_STAGES:0] carry;

  assign carry[0] = carry_en_i;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_ni  (clr_ni),
      .load_ni (load_ni),
      .par_en_i(cnt_en_i),
      .trk_en_i(carry[k]),
      .data_i  (data_i[k*STAGE_W +: STAGE_W]),
      .q_o     (count_o[k*STAGE_W +: STAGE_W]),
      .tc_o    (carry[k+1])
    );
  end

  assign tc_o = carry[N_STAGES];
endmodule

// File: rtl/sync_chain_counter_chk.sv
module sync_chain_counter_chk #(
  parameter int unsigned STAGE_W = 4,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic             cnt_en_i,
  input logic             carry_en_i,
  input logic [CNT_W-1:0] data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             tc_o
);
  logic run;
  assign run = clr_ni && load_ni && cnt_en_i && carry_en_i;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> count_o == '0); // R2
  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> count_o == $past(data_i)); // R3
  AST_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R4
  AST_HOLD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(cnt_en_i && carry_en_i)) |=> $stable(count_o)); // R5
  AST_TC_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o == ((&count_o) && carry_en_i)); // R6
  AST_LOAD_MAX_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni && (&data_i)) |=> tc_o == carry_en_i); // R8

  if (CNT_W > STAGE_W) begin : g_upper
    AST_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && !(&count_o[STAGE_W-1:0])) |=> $stable(count_o[CNT_W-1:STAGE_W])); // R7
  end
endmodule

bind sync_chain_counter sync_chain_counter_chk #(.STAGE_W(STAGE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_ni    (clr_ni),
  .load_ni   (load_ni),
  .cnt_en_i  (cnt_en_i),
  .carry_en_i(carry_en_i),
  .data_i    (data_i),
  .count_o   (count_o),
  .tc_o      (tc_o)
);

// File: tb/sync_chain_counter_tb.sv
`timescale 1ns/1ps
module sync_chain_counter_tb;
  localparam int unsigned W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_ni = 1'b1;
  logic         load_ni = 1'b1;
  logic         cnt_en_i = 1'b0;
  logic         carry_en_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] count_o;
  logic         tc_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;

  always #2.5 clk_i = ~clk_i;

  sync_chain_counter u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_ni    (clr_ni),
    .load_ni   (load_ni),
    .cnt_en_i  (cnt_en_i),
    .carry_en_i(carry_en_i),
    .data_i    (data_i),
    .count_o   (count_o),
    .tc_o      (tc_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check tc before edge, check count after edge
  task automatic step(input logic c, input logic l, input logic ce,
                      input logic te, input logic [W-1:0] d);
    string tag;
    @(negedge clk_i);
    clr_ni = c; load_ni = l; cnt_en_i = ce; carry_en_i = te; data_i = d;
    #1;
    chk("R6 tc", int'(tc_o), int'((model == 8'hFF) && te));
    if (!c) begin model = '0; tag = "R2 clear"; end
    else if (!l) begin model = d; tag = "R3 load"; end
    else if (ce && te) begin model = model + 8'd1; tag = "R4 count"; end
    else tag = "R5 hold";
    @(posedge clk_i);
    #1;
    chk(tag, int'(count_o), int'(model));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired before end of sequence");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset tc", int'(tc_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: clear under every combination of the other controls
    for (int m = 0; m < 8; m++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5);
      step(1'b0, m[0], m[1], m[2], 8'h5A);
    end
    // R2 from all ones
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF);

    // R3: all load values, enables varied
    for (int d = 0; d < 256; d++)
      step(1'b1, 1'b0, d[0], d[1], 8'(d));

    // R4 full count and wrap; R7 carry into upper stage
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 258; i++) begin
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h33);
      if (model == 8'h10) chk("R7 carry into upper", int'(count_o), 8'h10);
      if (model == 8'h0F) chk("R7 upper held", int'(count_o[7:4]), 0);
    end

    // R5 hold from two values, each disabled combination
    for (int v = 0; v < 2; v++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0, (v == 0) ? 8'h3C : 8'hFF);
      for (int m = 0; m < 3; m++)
        repeat (2) step(1'b1, 1'b1, m[0], m[1], 8'h00);
    end

    // R6: tc ignores cnt_en, follows carry_en at all ones
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    chk("R6 tc with cnt_en low", int'(tc_o), 1);
    step(1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    chk("R6 tc with carry_en low", int'(tc_o), 0);

    // R8: load all ones with carry_en low, then tc next cycle
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    @(negedge clk_i);
    clr_ni = 1'b1; load_ni = 1'b1; cnt_en_i = 1'b0; carry_en_i = 1'b1;
    #1;
    chk("R8 tc after load of max", int'(tc_o), 1);
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    chk("R8 wrap after load of max", int'(count_o), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule